// File: doc/BRIEF.md
# Microcoded Accumulator Core

A small accumulator machine with 12-bit words. Program and data share one memory that sits outside the core. Each instruction runs as a chain of register-transfer micro-steps, one step per clock. A step moves one value between the program counter, instruction register, memory address and data registers, the accumulator and a temporary operand register, or it strobes a memory read or write. The upper four bits of a word select the operation and the lower eight bits give a memory address.

The core drives an address, a read strobe, a write strobe and write data. The memory writes on the clock edge and returns read data for the current address within the same cycle. For checking, the core also exposes its program counter, its accumulator, a halted flag and a count of the micro-steps it has executed.

Top module: `acc_ucode_cpu`

## Requirements
- R1: While reset is held, the program counter, the accumulator and the step counter read 0, halted is 0 and no memory strobe is active. The first fetch after reset reads address 0.
- R2: Every instruction starts with three fetch steps and one decode step. Step 1 copies the program counter into the address register. In step 2, mem_rd is high with mem_addr equal to the program counter, and the program counter increments at the end of that step. Step 3 copies the fetched word into the instruction register. Step 4 decodes it.
- R3: Opcode 0x0 (load) takes 7 steps in total. The read of the address field happens in step 6, and the accumulator holds the memory word after step 7.
- R4: Opcode 0x4 (add) takes 8 steps in total. The read of the address field happens in step 6, and the operand is added to the accumulator after step 8. The sum wraps modulo 4096, so 0xFFF + 1 gives 0.
- R5: Opcode 0x8 (store) takes 7 steps in total. In step 7, mem_wr is high, mem_addr is the address field and mem_wdata is the accumulator.
- R6: Opcode 0xC (branch if zero) takes 5 steps in total. After step 5, the program counter holds the address field if the accumulator is 0. Otherwise the program counter keeps its incremented value.
- R7: The word 0xFFF halts the core after its decode step. The program counter is left one past the halt word. From then on, halted stays high, the program counter and the accumulator do not change, and no memory strobe is issued.
- R8: The step counter increments once per clock until halt and then holds its value.
- R9: Any other word is a no-op that takes only the 4 fetch and decode steps. This includes opcode 0xF with a nonzero address field.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory address (the address register) |
| mem_rd | output | 1 | Read strobe; data is taken at the end of the cycle |
| mem_wr | output | 1 | Write strobe; memory writes at the clock edge |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data for the current mem_addr |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| halted | output | 1 | High once the halt word has been decoded |
| cycle_count | output | CYC_W | Micro-steps executed since reset |

## Verification
The assertions check on every cycle that the read and write strobes never overlap. They also check that the fetch increment is exactly one, that a branch not taken leaves the program counter unchanged, that store data equals the accumulator, that the step counter advances, and that the halted state is sticky and frozen. The step count of each opcode, the values the accumulator takes, the wrap of the sum and the final memory image can only be shown by the bench. It runs two programs: a fill loop that stores 0x222 through 0xFFF and wraps to zero, and a short program with no-op words, a branch not taken and a branch taken. Both are compared every clock against a step-level reference model.

// File: rtl/acc_ucode_cpu.sv
module acc_ucode_cpu #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              halted,
  output logic [CYC_W-1:0]  cycle_count
);
  localparam int OP_W = DATA_W - ADDR_W;
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(4'h0);
  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(4'h4);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(4'h8);
  localparam logic [OP_W-1:0] OP_BRZ   = OP_W'(4'hC);
  localparam logic [DATA_W-1:0] HALT_WORD = '1;

  typedef enum logic [3:0] {
    S_FA, S_FB, S_FC, S_DEC, S_MA, S_RD, S_LD, S_TMP, S_SUM, S_SD, S_WR, S_BR, S_HALT
  } step_t;

  step_t step, nxt;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, mdr, acc, tmp;
  logic [CYC_W-1:0]  cyc;

  wire [OP_W-1:0]   op    = ir[DATA_W-1:ADDR_W];
  wire [ADDR_W-1:0] field = ir[ADDR_W-1:0];

  always_comb begin
    nxt = S_FA;
    case (step)
      S_FA:  nxt = S_FB;
      S_FB:  nxt = S_FC;
      S_FC:  nxt = S_DEC;
      S_DEC: begin
        if (ir == HALT_WORD) nxt = S_HALT;
        else if (op == OP_LOAD || op == OP_ADD || op == OP_STORE) nxt = S_MA;
        else if (op == OP_BRZ) nxt = S_BR;
        else nxt = S_FA;
      end
      S_MA:   nxt = (op == OP_STORE) ? S_SD : S_RD;
      S_RD:   nxt = (op == OP_ADD) ? S_TMP : S_LD;
      S_TMP:  nxt = S_SUM;
      S_SD:   nxt = S_WR;
      S_HALT: nxt = S_HALT;
      default: nxt = S_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= S_FA;
      pc   <= '0;
      mar  <= '0;
      ir   <= '0;
      mdr  <= '0;
      acc  <= '0;
      tmp  <= '0;
      cyc  <= '0;
    end else begin
      step <= nxt;
      if (step != S_HALT) cyc <= cyc + CYC_W'(1);
      case (step)
        S_FA:  mar <= pc;
        S_FB:  begin pc <= pc + ADDR_W'(1); mdr <= mem_rdata; end
        S_FC:  ir  <= mdr;
        S_MA:  mar <= field;
        S_RD:  mdr <= mem_rdata;
        S_LD:  acc <= mdr;
        S_TMP: tmp <= mdr;
        S_SUM: acc <= acc + tmp;
        S_SD:  mdr <= acc;
        S_BR:  if (acc == '0) pc <= field;
        default: ;
      endcase
    end
  end

  assign mem_addr    = mar;
  assign mem_rd      = (step == S_FB) || (step == S_RD);
  assign mem_wr      = (step == S_WR);
  assign mem_wdata   = mdr;
  assign pc_o        = pc;
  assign acc_o       = acc;
  assign halted      = (step == S_HALT);
  assign cycle_count = cyc;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R10
  AST_PC_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_FB) |=> pc == ADDR_W'($past(pc) + ADDR_W'(1))); // R2
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_wdata == acc); // R5
  AST_BR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_BR && acc != '0) |=> pc == $past(pc)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(acc) && !mem_rd && !mem_wr)); // R7
  AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> cycle_count == CYC_W'($past(cycle_count) + CYC_W'(1))); // R8
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(cycle_count)); // R8
endmodule

// File: tb/acc_ucode_cpu_tb_top.sv
module acc_ucode_cpu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [11:0] mem_wdata, mem_rdata;
  logic [7:0]  pc_o;
  logic [11:0] acc_o;
  logic        halted;
  logic [15:0] cycle_count;

  logic [11:0] mem [0:255];
  logic [11:0] m_mem [0:255];
  int m_pc, m_acc, m_ir, m_cyc, phase;
  bit m_halt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acc_ucode_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o), .acc_o(acc_o),
    .halted(halted), .cycle_count(cycle_count));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ilen(input int ir);
    case (ir >> 8)
      0: return 7;
      4: return 8;
      8: return 7;
      12: return 5;
      default: return 4;
    endcase
  endfunction

  function automatic string preq();
    if (m_halt) return "R7";
    if (phase < 4) return "R2";
    case (m_ir >> 8)
      0: return "R3";
      4: return "R4";
      8: return "R5";
      12: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_cycle();
    bit erd, ewr;
    int ea, op;
    string r;
    op = m_ir >> 8;
    erd = !m_halt && (phase == 1 || (phase == 5 && (op == 0 || op == 4)));
    ewr = !m_halt && phase == 6 && op == 8;
    ea  = (phase == 1) ? m_pc : (m_ir & 8'hFF);
    r = preq();
    chk(pc_o == 8'(m_pc) && acc_o == 12'(m_acc), r, {20'd0, pc_o, acc_o}, (m_pc << 12) | m_acc, "pc/acc");
    chk(halted == m_halt && cycle_count == 16'(m_cyc), (halted != m_halt) ? "R7" : "R8",
        cycle_count, m_cyc, "halted/step count");
    chk(mem_rd == erd && mem_wr == ewr, r, {mem_rd, mem_wr}, {erd, ewr}, "strobes");
    if (erd || ewr) chk(mem_addr == 8'(ea), r, mem_addr, ea, "mem_addr");
    if (ewr) chk(mem_wdata == 12'(m_acc), "R5", mem_wdata, m_acc, "mem_wdata");
    chk(!(mem_rd && mem_wr), "R10", {mem_rd, mem_wr}, 0, "strobe overlap");
  endtask

  task automatic model_step();
    int f;
    if (m_halt) return;
    m_cyc++;
    f = m_ir & 8'hFF;
    case (phase)
      1: begin m_ir = m_mem[m_pc]; m_pc = (m_pc + 1) & 8'hFF; end
      3: if (m_ir == 12'hFFF) m_halt = 1;
      default: ;
    endcase
    if (phase >= 3 && phase == ilen(m_ir) - 1) begin
      case (m_ir >> 8)
        0: m_acc = m_mem[f];
        4: m_acc = (m_acc + m_mem[f]) & 12'hFFF;
        8: m_mem[f] = 12'(m_acc);
        12: if (m_acc == 0) m_pc = f;
        default: ;
      endcase
      phase = 0;
    end else phase++;
  endtask

  task automatic run_prog(input int limit);
    int n = 0;
    int tail = 0;
    for (int i = 0; i < 256; i++) m_mem[i] = mem[i];
    m_pc = 0; m_acc = 0; m_ir = 0; m_cyc = 0; phase = 0; m_halt = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(pc_o == 0 && acc_o == 0, "R1", {pc_o, acc_o}, 0, "reset pc/acc");
    chk(!halted && cycle_count == 0 && !mem_rd && !mem_wr, "R1",
        {halted, mem_rd, mem_wr, cycle_count}, 0, "reset flags");
    rst_n = 1'b1;
    while (tail < 4) begin
      compare_cycle();
      if (m_halt) tail++;
      n++;
      if (n > limit) begin
        chk(0, "R7", n, limit, "per-run watchdog, no halt");
        break;
      end
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
    for (int i = 0; i < 256; i++)
      if (mem[i] != m_mem[i]) chk(0, "R5", mem[i], m_mem[i], $sformatf("memory word %0h", i));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 12'h000;
    mem[8'h01] = 12'hC12;
    mem[8'h10] = 12'h001;
    mem[8'h11] = 12'h111;
    mem[8'h12] = 12'h011;
    for (int k = 2; k < 16; k++) begin
      mem[8'h13 + 2*(k-2)] = 12'h411;
      mem[8'h14 + 2*(k-2)] = 12'(12'h800 | k);
    end
    mem[8'h2F] = 12'h410;
    mem[8'h30] = 12'h810;
    mem[8'h31] = 12'hFFF;
    run_prog(2000);
    for (int k = 2; k < 16; k++)
      chk(mem[k] == 12'(k * 12'h111), "R5", mem[k], k * 12'h111, $sformatf("fill word %0h", k));
    chk(mem[8'h10] == 12'h000, "R4", mem[8'h10], 0, "wrapped sum stored");
    chk(pc_o == 8'h32, "R7", pc_o, 8'h32, "pc past halt");
    chk(cycle_count == 16'd248, "R8", cycle_count, 248, "total steps program 1");

    for (int i = 0; i < 256; i++) mem[i] = 12'h000;
    mem[8'h00] = 12'h020;
    mem[8'h01] = 12'hC10;
    mem[8'h02] = 12'h1AB;
    mem[8'h03] = 12'hF00;
    mem[8'h04] = 12'h421;
    mem[8'h05] = 12'hC08;
    mem[8'h06] = 12'hFFF;
    mem[8'h08] = 12'h822;
    mem[8'h09] = 12'hFFF;
    mem[8'h20] = 12'h005;
    mem[8'h21] = 12'hFFB;
    mem[8'h22] = 12'h777;
    run_prog(2000);
    chk(pc_o == 8'h0A, "R6", pc_o, 8'h0A, "taken branch skipped halt at 6");
    chk(mem[8'h22] == 12'h000 && acc_o == 12'h000, "R4", mem[8'h22], 0, "5+FFB wraps to 0");
    chk(cycle_count == 16'd44, "R9", cycle_count, 44, "no-ops take 4 steps each");
    chk(mem[8'h02] == 12'h1AB && mem[8'h03] == 12'hF00, "R9", mem[8'h03], 12'hF00, "no-op words untouched");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule